// File: doc/BRIEF.md
# Overlapping-Window Byte Memory

This block is a small on-chip memory in which every byte carries its own address. Reading a word at any byte address N returns the four consecutive bytes N..N+3 packed little-end-first. No alignment is required, so neighbouring addresses give windows that overlap by three bytes. Data always moves as a full 32-bit word, even when the operation concerns a single byte.

A requester issues one operation at a time: an opcode, a byte address and write data, qualified by `req_valid`. There are four operations. A word load returns the window. A byte load returns the window with everything above bit 7 cleared. A word store writes the four window bytes in one step. A byte store runs as an explicit read, mask-and-merge, then write-back sequence rather than using per-byte write strobes. The block signals completion with a one-cycle `done` pulse. It holds `busy` while an operation is open and reports windows that would run past the last byte as errors.

Top module: `overlap_word_mem`

## Requirements
- R1: After reset, `busy`, `done`, `rd_valid` and `err` are low and every stored byte is zero.
- R2: Opcode 2'b00 (word load) at address N returns {byte N+3, byte N+2, byte N+1, byte N}, with byte N in bits 7:0. `done` and `rd_valid` are high in the cycle after the accepting edge.
- R3: Opcode 2'b01 (byte load) at address N returns byte N in bits 7:0 and zeros in bits 31:8, with the same one-cycle timing as R2.
- R4: Opcode 2'b10 (word store) writes `req_wdata[7:0]` to byte N and so on up to `req_wdata[31:24]` to byte N+3. `done` is high in the cycle after the accepting edge.
- R5: Opcode 2'b11 (byte store) at N replaces byte N with `req_wdata[7:0]` and leaves bytes N+1..N+3 and all other bytes unchanged. `done` is high exactly four cycles after the accepting edge.
- R6: `busy` is high from the cycle after an accepted request through its `done` cycle. A request presented while `busy` is high is ignored and writes nothing.
- R7: A request whose window end N+3 is at or beyond DEPTH completes with `err` and `done` high one cycle after acceptance, with `rd_valid` low and no byte written.
- R8: `done` lasts exactly one cycle per operation, and `rd_valid` is high only in the `done` cycle of a load that was in range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation: 00 word load, 01 byte load, 10 word store, 11 byte store |
| req_addr | input | AW | Byte address of the window start, AW = clog2(DEPTH) |
| req_wdata | input | 32 | Store data; byte store uses bits 7:0 |
| busy | output | 1 | An accepted operation has not yet finished |
| done | output | 1 | One-cycle completion pulse |
| rd_valid | output | 1 | `rd_data` holds a load result this cycle |
| rd_data | output | 32 | Load result |
| err | output | 1 | Completed operation was out of range |

## Verification
A new request can arrive while a byte store is still in its read, merge or write cycles, and the two would compete for the storage ports. The bench provokes this by holding a word store to another address on the request inputs through every cycle of a byte store, including its `done` cycle. It then judges the collision by reading that address back and finding it unchanged, and by finding the byte store's own result intact. The sweeps also run byte stores at every address of a 16-byte configuration and compare each affected window against a reference byte array.

// File: rtl/owm_pkg.sv
package owm_pkg;

    localparam int WORD_W    = 32;
    localparam int WIN_BYTES = WORD_W / 8;

    typedef enum logic [1:0] {
        OP_LDW = 2'b00,
        OP_LDB = 2'b01,
        OP_STW = 2'b10,
        OP_STB = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_MERGE,
        ST_WRITE,
        ST_DONE
    } state_e;

    typedef struct packed {
        logic                rd_valid;
        logic                err;
        logic [WORD_W-1:0]   rd_data;
    } result_t;

    // Clear the lowest byte lane of a window and insert a new byte there.
    function automatic logic [WORD_W-1:0] merge_low(input logic [WORD_W-1:0] win,
                                                    input logic [7:0]        b);
        return (win & 32'hFFFF_FF00) | {24'h0, b};
    endfunction

    // Keep only the lowest byte lane of a window.
    function automatic logic [WORD_W-1:0] keep_low(input logic [WORD_W-1:0] win);
        return win & 32'h0000_00FF;
    endfunction

endpackage

// File: rtl/owm_byte_array.sv
module owm_byte_array
    import owm_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rword,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wword
);

    localparam logic [AW:0] DEPTH_W = DEPTH[AW:0];

    logic [7:0]  mem  [DEPTH];
    logic [AW:0] ridx [WIN_BYTES];
    logic [AW:0] widx [WIN_BYTES];

    // One read lane per window byte; lanes past the end read as zero.
    for (genvar g = 0; g < WIN_BYTES; g++) begin : g_lane
        assign ridx[g] = {1'b0, raddr} + (AW+1)'(g);
        assign widx[g] = {1'b0, waddr} + (AW+1)'(g);
        assign rword[8*g +: 8] = (ridx[g] < DEPTH_W) ? mem[ridx[g][AW-1:0]] : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) begin
                mem[k] <= 8'h00;
            end
        end else if (we) begin
            for (int k = 0; k < WIN_BYTES; k++) begin
                if (widx[k] < DEPTH_W) begin
                    mem[widx[k][AW-1:0]] <= wword[8*k +: 8];
                end
            end
        end
    end

endmodule

// File: rtl/owm_range_chk.sv
module owm_range_chk
    import owm_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic [AW-1:0] addr,
    output logic          in_range
);

    localparam logic [AW:0] DEPTH_W = DEPTH[AW:0];
    localparam logic [AW:0] SPAN    = (AW+1)'(WIN_BYTES - 1);

    logic [AW:0] last_byte;

    assign last_byte = {1'b0, addr} + SPAN;
    assign in_range  = last_byte < DEPTH_W;

endmodule

// File: rtl/owm_ctrl.sv
module owm_ctrl
    import owm_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [AW-1:0]     req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic              in_range,
    input  logic [WORD_W-1:0] rword,
    output logic [AW-1:0]     raddr,
    output logic              we,
    output logic [AW-1:0]     waddr,
    output logic [WORD_W-1:0] wword,
    output logic              busy,
    output logic              done,
    output result_t           res
);

    state_e          state;
    logic [AW-1:0]   addr_q;
    logic [7:0]      byte_q;
    logic [WORD_W-1:0] win_q;
    op_e             op_in;
    logic            accept;

    assign op_in  = op_e'(req_op);
    assign accept = req_valid && (state == ST_IDLE);

    // The read lanes follow the request while idle, the held address otherwise.
    assign raddr = (state == ST_IDLE) ? req_addr : addr_q;

    assign we    = (accept && op_in == OP_STW && in_range) || (state == ST_WRITE);
    assign waddr = (state == ST_WRITE) ? addr_q : req_addr;
    assign wword = (state == ST_WRITE) ? win_q  : req_wdata;

    assign busy = (state != ST_IDLE);
    assign done = (state == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            byte_q <= '0;
            win_q  <= '0;
            res    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        res.rd_valid <= 1'b0;
                        res.err      <= !in_range;
                        if (!in_range) begin
                            state <= ST_DONE;
                        end else begin
                            unique case (op_in)
                                OP_LDW: begin
                                    res.rd_data  <= rword;
                                    res.rd_valid <= 1'b1;
                                    state        <= ST_DONE;
                                end
                                OP_LDB: begin
                                    res.rd_data  <= keep_low(rword);
                                    res.rd_valid <= 1'b1;
                                    state        <= ST_DONE;
                                end
                                OP_STW: begin
                                    state <= ST_DONE;
                                end
                                OP_STB: begin
                                    addr_q <= req_addr;
                                    byte_q <= req_wdata[7:0];
                                    state  <= ST_READ;
                                end
                            endcase
                        end
                    end
                end
                ST_READ: begin
                    win_q <= rword;
                    state <= ST_MERGE;
                end
                ST_MERGE: begin
                    win_q <= merge_low(win_q, byte_q);
                    state <= ST_WRITE;
                end
                ST_WRITE: begin
                    state <= ST_DONE;
                end
                ST_DONE: begin
                    res.rd_valid <= 1'b0;
                    res.err      <= 1'b0;
                    state        <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/overlap_word_mem.sv
module overlap_word_mem
    import owm_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [31:0]   req_wdata,
    output logic          busy,
    output logic          done,
    output logic          rd_valid,
    output logic [31:0]   rd_data,
    output logic          err
);

    logic [AW-1:0]     raddr;
    logic [AW-1:0]     waddr;
    logic [WORD_W-1:0] rword;
    logic [WORD_W-1:0] wword;
    logic              we;
    logic              in_range;
    result_t           res;

    owm_range_chk #(.DEPTH(DEPTH), .AW(AW)) u_range (
        .addr     (req_addr),
        .in_range (in_range)
    );

    owm_byte_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
        .clk   (clk),
        .rst   (rst),
        .raddr (raddr),
        .rword (rword),
        .we    (we),
        .waddr (waddr),
        .wword (wword)
    );

    owm_ctrl #(.AW(AW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .in_range  (in_range),
        .rword     (rword),
        .raddr     (raddr),
        .we        (we),
        .waddr     (waddr),
        .wword     (wword),
        .busy      (busy),
        .done      (done),
        .res       (res)
    );

    assign rd_valid = res.rd_valid;
    assign rd_data  = res.rd_data;
    assign err      = res.err;

endmodule

// File: rtl/owm_checker.sv
module owm_checker #(
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic [1:0]    req_op,
    input logic [AW-1:0] req_addr,
    input logic          busy,
    input logic          done,
    input logic          rd_valid,
    input logic          err
);

    localparam logic [AW:0] DEPTH_W = DEPTH[AW:0];

    logic fits;
    logic take;
    assign fits = ({1'b0, req_addr} + (AW+1)'(3)) < DEPTH_W;
    assign take = req_valid && !busy;

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_valid_in_done: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> done);

    a_r6_busy_with_done: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    a_r6_accept_sets_busy: assert property (@(posedge clk) disable iff (rst)
        take |=> busy);

    a_r2_load_latency: assert property (@(posedge clk) disable iff (rst)
        (take && !req_op[1] && fits) |=> (done && rd_valid && !err));

    a_r4_wstore_latency: assert property (@(posedge clk) disable iff (rst)
        (take && req_op == 2'b10 && fits) |=> (done && !rd_valid && !err));

    a_r5_bstore_latency: assert property (@(posedge clk) disable iff (rst)
        (take && req_op == 2'b11 && fits) |=> !done ##1 !done ##1 !done ##1 (done && !rd_valid));

    a_r7_range_error: assert property (@(posedge clk) disable iff (rst)
        (take && !fits) |=> (done && err && !rd_valid));

endmodule

bind overlap_word_mem owm_checker #(.DEPTH(DEPTH), .AW(AW)) u_owm_checker (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .busy      (busy),
    .done      (done),
    .rd_valid  (rd_valid),
    .err       (err)
);

// File: tb/overlap_word_mem_bench.sv
`timescale 1ns/1ps
module overlap_word_mem_bench;

    localparam int DEPTH = 16;
    localparam int AW    = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid;
    logic [1:0]    req_op;
    logic [AW-1:0] req_addr;
    logic [31:0]   req_wdata;
    logic          busy, done, rd_valid, err;
    logic [31:0]   rd_data;

    int checks = 0;
    int errors = 0;
    logic [7:0] ref_mem [DEPTH];

    always #4 clk = ~clk;

    overlap_word_mem #(.DEPTH(DEPTH)) u_overlap_word_mem (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_valid(rd_valid), .rd_data(rd_data), .err(err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    function automatic bit fits(input int a);
        return (a + 3) < DEPTH;
    endfunction

    function automatic logic [31:0] ref_win(input int a);
        logic [31:0] w = '0;
        for (int k = 0; k < 4; k++) begin
            if (a + k < DEPTH) w[8*k +: 8] = ref_mem[a + k];
        end
        return w;
    endfunction

    // Issue one request and wait for its completion at falling edges.
    task automatic run_op(input logic [1:0] op, input int a, input logic [31:0] wd,
                          input string req, output logic [31:0] rd,
                          output logic v, output logic e);
        int lat;
        int exp_lat;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a[AW-1:0]; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            chk(busy === 1'b1, "R6", "busy while open", {31'h0, busy}, 32'h1);
            @(negedge clk);
            lat++;
        end
        exp_lat = (op == 2'b11 && fits(a)) ? 4 : 1;
        chk(lat == exp_lat, req, "done latency", lat, exp_lat);
        chk(busy === 1'b1, "R6", "busy in done cycle", {31'h0, busy}, 32'h1);
        rd = rd_data; v = rd_valid; e = err;
        chk(e === !fits(a), "R7", "err flag", {31'h0, e}, {31'h0, !fits(a)});
        chk(v === (fits(a) && !op[1]), "R8", "rd_valid", {31'h0, v},
            {31'h0, fits(a) && !op[1]});
        @(negedge clk);
        chk(done === 1'b0, "R8", "done single cycle", {31'h0, done}, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] rd;
        logic v, e;
        req_valid = 0; req_op = 0; req_addr = 0; req_wdata = 0;
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'h00;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({busy, done, rd_valid, err} === 4'b0, "R1", "outputs after reset",
            {28'h0, busy, done, rd_valid, err}, 32'h0);

        // R1: cleared contents
        for (int a = 0; a < DEPTH - 3; a++) begin
            run_op(2'b00, a, 32'h0, "R1", rd, v, e);
            chk(rd === 32'h0, "R1", "zero window", rd, 32'h0);
        end

        // R4: aligned word fill with computed pattern
        for (int a = 0; a < DEPTH; a += 4) begin
            logic [31:0] w;
            for (int k = 0; k < 4; k++) w[8*k +: 8] = 8'((a + k) * 37 + 5);
            run_op(2'b10, a, w, "R4", rd, v, e);
            for (int k = 0; k < 4; k++) ref_mem[a + k] = w[8*k +: 8];
        end
        // R4: unaligned word store and an out-of-range one (R7)
        run_op(2'b10, 5, 32'hCAFE_F00D, "R4", rd, v, e);
        for (int k = 0; k < 4; k++) ref_mem[5 + k] = 8'(32'hCAFE_F00D >> (8 * k));
        run_op(2'b10, 13, 32'h1234_5678, "R7", rd, v, e);

        // R2 and R3: every address, in and out of range
        for (int a = 0; a < DEPTH; a++) begin
            run_op(2'b00, a, 32'h0, "R2", rd, v, e);
            if (fits(a)) chk(rd === ref_win(a), "R2", "word window", rd, ref_win(a));
            run_op(2'b01, a, 32'h0, "R3", rd, v, e);
            if (fits(a)) chk(rd === {24'h0, ref_mem[a]}, "R3", "byte load", rd,
                             {24'h0, ref_mem[a]});
        end
        // R7: the out-of-range store at 13 left bytes 12..15 untouched
        run_op(2'b00, 12, 32'h0, "R7", rd, v, e);
        chk(rd === ref_win(12), "R7", "no write on error", rd, ref_win(12));

        // R5: byte store at every address; neighbours checked via window
        for (int a = 0; a < DEPTH; a++) begin
            logic [7:0] b = 8'hA0 ^ 8'(a * 3);
            run_op(2'b11, a, {24'hFFFFFF, b}, "R5", rd, v, e);
            if (fits(a)) ref_mem[a] = b;
            if (fits(a)) begin
                run_op(2'b00, a, 32'h0, "R5", rd, v, e);
                chk(rd === ref_win(a), "R5", "merged window", rd, ref_win(a));
            end
        end

        // R6: request held during a byte store is ignored
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'b11; req_addr = 4'd2; req_wdata = 32'h0000_005A;
        @(negedge clk);
        req_op = 2'b10; req_addr = 4'd8; req_wdata = 32'hDEAD_BEEF;
        for (int c = 1; c <= 4; c++) begin
            chk(busy === 1'b1, "R6", "busy during store", {31'h0, busy}, 32'h1);
            chk(done === (c == 4), "R5", "done timing under load", {31'h0, done},
                {31'h0, c == 4});
            @(negedge clk);
        end
        req_valid = 1'b0;
        ref_mem[2] = 8'h5A;
        run_op(2'b00, 8, 32'h0, "R6", rd, v, e);
        chk(rd === ref_win(8), "R6", "ignored store wrote nothing", rd, ref_win(8));
        run_op(2'b00, 0, 32'h0, "R6", rd, v, e);
        chk(rd === ref_win(0), "R6", "byte store survived", rd, ref_win(0));

        // Final full scan by byte loads
        for (int a = 0; a < DEPTH - 3; a++) begin
            run_op(2'b01, a, 32'h0, "R3", rd, v, e);
            chk(rd === {24'h0, ref_mem[a]}, "R3", "final scan", rd, {24'h0, ref_mem[a]});
        end
        summary();
    end

endmodule